// File: doc/BRIEF.md
# Per-Core Countdown Timer

This block is a down-counting timer of the kind each core of a multiprocessor cluster owns privately. Software reaches it through a small register port: a byte address, a write strobe, write data and combinational read data. There are four registers: a reload value, the live count, a control word and an interrupt status word. Once enabled, the count falls by one after every (P+1) clock cycles, where P is an 8-bit divide value in the control word.

When the count reaches zero, the status bit is set. In auto-reload mode the count is refilled from the reload register and keeps running. In one-shot mode it stays at zero, and a count of zero means the timer is stopped. The interrupt output is a single-cycle pulse that fires only when the status bit rises. Software clears the status by writing a one to it.

Top module: `pct_timer`

## Requirements
- R1: A synchronous active-high reset clears every register and the prescaler phase. After reset every read returns 0 and `irq_o` is low.
- R2: The registers are decoded at byte offsets 0x0 (reload), 0x4 (count), 0x8 (control) and 0xC (status). A read at any other offset returns 0, and a write there changes nothing.
- R3: A write to offset 0x0 stores the value in both the reload register and the count. A write to offset 0x4 changes only the count.
- R4: Control bit 0 enables the timer and control bits 15:8 hold the divide value P. While the timer is enabled and the count is non-zero, the count drops by one every P+1 cycles. A write to the count or reload register, or a rising enable, restarts the divide phase. The count therefore reaches zero N*(P+1) cycles after the restart edge.
- R5: Control bit 1 selects auto-reload. In one-shot mode (bit 1 = 0), reaching zero sets status bit 0 and the count stays at 0 with no further change.
- R6: In auto-reload mode, reaching zero sets status bit 0 and refills the count from the reload register in the same cycle. Counting then continues.
- R7: Reading the count returns 0 while the timer is disabled or the count is 0. A control write never changes the count, except for the preload in R8.
- R8: If a control write takes enable from 0 to 1 while the count is 0 and bit 1 of the written value is set, the count is first loaded from the reload register.
- R9: Writing offset 0xC with bit 0 set clears the status bit. If the status is set in the same cycle, the set wins.
- R10: `irq_o` is high for exactly one cycle, and only in the cycle in which the status bit changes from 0 to 1. A status bit that is already set causes no further pulse.
- R11: A count or reload write landing in the same cycle in which the count would expire takes priority. The new value is loaded and the status is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Byte offset of the accessed register |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, combinational from `addr_i` |
| irq_o | output | 1 | One-cycle pulse on a rising status bit |

## Verification
Read data is combinational, so a register written at edge E reads back its new value once that edge has passed. Expiry is due exactly N*(P+1) edges after the restart edge E, and `irq_o` rises in that same cycle together with the status bit. The bench samples 2 ns after each edge. It checks that status and `irq_o` are still low one edge before the due cycle, that both are high in the due cycle, and that `irq_o` has dropped one cycle later. Writes meant to collide with an expiry are timed to land on the computed expiry edge.

// File: rtl/pct_pkg.sv
package pct_pkg;
   // Register byte offsets (decoded in full against the address width)
   localparam int unsigned OFF_RELOAD = 0;
   localparam int unsigned OFF_COUNT  = 4;
   localparam int unsigned OFF_CTRL   = 8;
   localparam int unsigned OFF_STAT   = 12;
   // Control word bit positions
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_AUTO_BIT = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RELOAD,
      SEL_COUNT,
      SEL_CTRL,
      SEL_STAT
   } pct_sel_e;
endpackage

// File: rtl/pct_prescale.sv
module pct_prescale #(
   parameter int unsigned PW     = 8,
   parameter bit          BYPASS = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          run_i,
   input  logic          restart_i,
   input  logic [PW-1:0] div_i,
   output logic          tick_o
);
   generate
      if (BYPASS) begin : g_bypass
         // No divide field: one decrement per enabled cycle
         assign tick_o = run_i && !restart_i;
      end else begin : g_div
         logic [PW-1:0] phase_q;
         logic          at_end;

         assign at_end = (phase_q == div_i);
         assign tick_o = run_i && !restart_i && at_end;

         always_ff @(posedge clk_i) begin
            if (rst_i || restart_i || !run_i) begin
               phase_q <= '0;
            end else if (at_end) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pct_down.sv
module pct_down #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ld_i,
   input  logic [DATA_W-1:0] ld_val_i,
   input  logic              preload_i,
   input  logic [DATA_W-1:0] reload_i,
   input  logic              tick_i,
   input  logic              auto_i,
   output logic [DATA_W-1:0] cnt_o,
   output logic              expire_o
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] cnt_d;

   // A register write in the same cycle suppresses the expiry
   assign expire_o = tick_i && !ld_i && (cnt_q == ONE);

   always_comb begin
      cnt_d = cnt_q;
      if (ld_i) begin
         cnt_d = ld_val_i;
      end else if (preload_i) begin
         cnt_d = reload_i;
      end else if (expire_o) begin
         cnt_d = auto_i ? reload_i : '0;
      end else if (tick_i) begin
         cnt_d = cnt_q - ONE;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/pct_regs.sv
module pct_regs
   import pct_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned PRE_LSB = 8,
   parameter int unsigned PRE_W   = 8,
   parameter int unsigned PW      = (PRE_W > 0) ? PRE_W : 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [DATA_W-1:0] cnt_i,
   input  logic              expire_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DATA_W-1:0] reload_o,
   output logic              en_o,
   output logic              auto_o,
   output logic [PW-1:0]     div_o,
   output logic              wr_cnt_o,
   output logic              en_rise_o,
   output logic              preload_o,
   output logic              stat_o,
   output logic              irq_o
);
   pct_sel_e          sel;
   logic [DATA_W-1:0] reload_q;
   logic [DATA_W-1:0] ctrl_q;
   logic              stat_q;
   logic              stat_d;
   logic              irq_q;
   logic              wr_reload, wr_count, wr_ctrl, wr_stat;

   always_comb begin
      unique case (addr_i)
         ADDR_W'(OFF_RELOAD): sel = SEL_RELOAD;
         ADDR_W'(OFF_COUNT):  sel = SEL_COUNT;
         ADDR_W'(OFF_CTRL):   sel = SEL_CTRL;
         ADDR_W'(OFF_STAT):   sel = SEL_STAT;
         default:             sel = SEL_NONE;
      endcase
   end

   assign wr_reload = wr_en_i && (sel == SEL_RELOAD);
   assign wr_count  = wr_en_i && (sel == SEL_COUNT);
   assign wr_ctrl   = wr_en_i && (sel == SEL_CTRL);
   assign wr_stat   = wr_en_i && (sel == SEL_STAT);

   assign en_o      = ctrl_q[CTRL_EN_BIT];
   assign auto_o    = ctrl_q[CTRL_AUTO_BIT];
   assign wr_cnt_o  = wr_reload || wr_count;
   assign en_rise_o = wr_ctrl && wr_data_i[CTRL_EN_BIT] && !en_o;
   assign preload_o = en_rise_o && wr_data_i[CTRL_AUTO_BIT] && (cnt_i == '0);

   generate
      if (PRE_W > 0) begin : g_div_field
         assign div_o = ctrl_q[PRE_LSB +: PW];
      end else begin : g_no_div
         assign div_o = '0;
      end
   endgenerate

   // Status: expiry sets, a one in bit 0 clears, set wins
   always_comb begin
      stat_d = stat_q;
      if (wr_stat && wr_data_i[0]) stat_d = 1'b0;
      if (expire_i)                stat_d = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         reload_q <= '0;
         ctrl_q   <= '0;
         stat_q   <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_reload) reload_q <= wr_data_i;
         if (wr_ctrl)   ctrl_q   <= wr_data_i;
         stat_q <= stat_d;
         irq_q  <= stat_d && !stat_q;
      end
   end

   always_comb begin
      rd_data_o = '0;
      unique case (sel)
         SEL_RELOAD: rd_data_o = reload_q;
         SEL_COUNT:  rd_data_o = (en_o && (cnt_i != '0)) ? cnt_i : '0;
         SEL_CTRL:   rd_data_o = ctrl_q;
         SEL_STAT:   rd_data_o = {{(DATA_W-1){1'b0}}, stat_q};
         default:    rd_data_o = '0;
      endcase
   end

   assign reload_o = reload_q;
   assign stat_o   = stat_q;
   assign irq_o    = irq_q;
endmodule

// File: rtl/pct_timer.sv
module pct_timer #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned PRE_LSB = 8,
   parameter int unsigned PRE_W   = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);
   localparam int unsigned PW = (PRE_W > 0) ? PRE_W : 1;

   generate
      if (DATA_W < 16) begin : g_bad_data_w
         $error("pct_timer: DATA_W must be at least 16");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("pct_timer: ADDR_W must cover offset 0xC");
      end
      if (PRE_LSB < 2 || PRE_LSB + PRE_W > DATA_W) begin : g_bad_div
         $error("pct_timer: divide field overlaps control bits or exceeds DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] reload_q;
   logic [PW-1:0]     div;
   logic              en, auto_rl, wr_cnt, en_rise, preload;
   logic              expire, tick, run, stat_q;

   assign run = en && (cnt_q != '0);

   pct_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .PRE_LSB(PRE_LSB),
      .PRE_W  (PRE_W),
      .PW     (PW)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .wr_en_i  (wr_en_i),
      .addr_i   (addr_i),
      .wr_data_i(wr_data_i),
      .cnt_i    (cnt_q),
      .expire_i (expire),
      .rd_data_o(rd_data_o),
      .reload_o (reload_q),
      .en_o     (en),
      .auto_o   (auto_rl),
      .div_o    (div),
      .wr_cnt_o (wr_cnt),
      .en_rise_o(en_rise),
      .preload_o(preload),
      .stat_o   (stat_q),
      .irq_o    (irq_o)
   );

   pct_prescale #(
      .PW    (PW),
      .BYPASS(PRE_W == 0)
   ) u_pre (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .run_i    (run),
      .restart_i(wr_cnt || en_rise),
      .div_i    (div),
      .tick_o   (tick)
   );

   pct_down #(
      .DATA_W(DATA_W)
   ) u_down (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .ld_i     (wr_cnt),
      .ld_val_i (wr_data_i),
      .preload_i(preload),
      .reload_i (reload_q),
      .tick_i   (tick),
      .auto_i   (auto_rl),
      .cnt_o    (cnt_q),
      .expire_o (expire)
   );
endmodule

// File: rtl/pct_timer_chk.sv
module pct_timer_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              irq_i,
   input logic [DATA_W-1:0] cnt_i,
   input logic [DATA_W-1:0] reload_i,
   input logic              stat_i,
   input logic              expire_i,
   input logic              auto_i,
   input logic              en_i,
   input logic              tick_i
);
   logic w_rl, w_cn, w_ct, w_st;
   assign w_rl = wr_en_i && (addr_i == ADDR_W'(0));
   assign w_cn = wr_en_i && (addr_i == ADDR_W'(4));
   assign w_ct = wr_en_i && (addr_i == ADDR_W'(8));
   assign w_st = wr_en_i && (addr_i == ADDR_W'(12));

   AST_RELOAD_MIRROR: assert property (@(posedge clk_i) disable iff (rst_i)
      w_rl |=> (cnt_i == $past(wr_data_i)) && (reload_i == $past(wr_data_i))); // R3
   AST_COUNT_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
      w_cn |=> (cnt_i == $past(wr_data_i)) && (reload_i == $past(reload_i))); // R3
   AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_i != '0) && !w_rl && !w_cn && !tick_i |=> $stable(cnt_i)); // R7
   AST_ZERO_STAYS: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_i == '0) && !w_rl && !w_cn && !w_ct |=> (cnt_i == '0)); // R5
   AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
      expire_i && !auto_i |=> (cnt_i == '0) && stat_i); // R5
   AST_AUTO_REFILL: assert property (@(posedge clk_i) disable iff (rst_i)
      expire_i && auto_i |=> (cnt_i == $past(reload_i)) && stat_i); // R6
   AST_ENABLE_PRELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
      w_ct && wr_data_i[0] && wr_data_i[1] && !en_i && (cnt_i == '0)
      |=> (cnt_i == $past(reload_i))); // R8
   AST_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
      w_st && wr_data_i[0] && !expire_i |=> !stat_i); // R9
   AST_IRQ_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |-> (irq_i == (stat_i && !$past(stat_i)))); // R10
   AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_i |=> !irq_i); // R10
endmodule

bind pct_timer pct_timer_chk #(
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .wr_en_i  (wr_en_i),
   .addr_i   (addr_i),
   .wr_data_i(wr_data_i),
   .irq_i    (irq_o),
   .cnt_i    (cnt_q),
   .reload_i (reload_q),
   .stat_i   (stat_q),
   .expire_i (expire),
   .auto_i   (auto_rl),
   .en_i     (en),
   .tick_i   (tick)
);

// File: tb/tb_pct_timer.sv
module tb_pct_timer;
   logic        clk = 1'b0;
   logic        rst;
   logic        wen;
   logic [3:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        irq;
   int          nchk  = 0;
   int          nfail = 0;
   bit          done  = 1'b0;

   always #4 clk = ~clk;

   pct_timer dut (
      .clk_i    (clk),
      .rst_i    (rst),
      .wr_en_i  (wen),
      .addr_i   (addr),
      .wr_data_i(wdata),
      .rd_data_o(rdata),
      .irq_o    (irq)
   );

   // divide P, count N, auto-reload flag
   localparam logic [24:0] VEC [6] = '{
      {8'd0, 16'd1, 1'b0},
      {8'd0, 16'd5, 1'b0},
      {8'd3, 16'd4, 1'b0},
      {8'd1, 16'd7, 1'b1},
      {8'd7, 16'd3, 1'b1},
      {8'd2, 16'd1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      addr = a; wdata = d; wen = 1'b1;
      @(posedge clk); #2;
      wen = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      wen = 1'b0; addr = a; #1; v = rdata;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int          pulses;
      rst = 1'b1; wen = 1'b0; addr = '0; wdata = '0;
      step(3);
      rst = 1'b0;
      // R1: reset state
      for (int a = 0; a < 16; a += 4) begin
         rd(4'(a), v); chk("R1 reset read", v, 32'h0);
      end
      chk("R1 irq low", {31'b0, irq}, 32'h0);

      // R2: unmapped offsets
      wr(4'h2, 32'hFFFF_FFFF);
      wr(4'hD, 32'hFFFF_FFFF);
      rd(4'h2, v); chk("R2 unmapped read", v, 32'h0);
      rd(4'h6, v); chk("R2 unmapped read", v, 32'h0);
      rd(4'h0, v); chk("R2 no side effect reload", v, 32'h0);
      rd(4'h8, v); chk("R2 no side effect ctrl", v, 32'h0);

      // R3: reload write mirrors into count, count write does not touch reload
      wr(4'h0, 32'd50);
      wr(4'h8, 32'h0000_FF01);
      rd(4'h4, v); chk("R3 reload mirrored to count", v, 32'd50);
      wr(4'h4, 32'd9);
      rd(4'h0, v); chk("R3 reload kept", v, 32'd50);
      rd(4'h4, v); chk("R3 count written", v, 32'd9);

      // R7: disable hides count, control writes keep it
      wr(4'h4, 32'd50);
      wr(4'h8, 32'h0000_FF00);
      rd(4'h4, v); chk("R7 disabled reads 0", v, 32'h0);
      wr(4'h8, 32'h0000_FF01);
      rd(4'h4, v); chk("R7 count kept over ctrl writes", v, 32'd50);
      wr(4'h8, 32'h0);

      // R4 R5 R6 R10: table walk, expiry due N*(P+1) edges after the enable edge
      foreach (VEC[i]) begin
         automatic logic [7:0]  p  = VEC[i][24:17];
         automatic logic [15:0] n  = VEC[i][16:1];
         automatic logic        au = VEC[i][0];
         automatic int          k  = int'(n) * (int'(p) + 1);
         wr(4'h8, 32'h0);
         wr(4'hC, 32'h1);
         wr(4'h0, {16'h0, n});
         wr(4'h8, {16'h0, p, 6'b0, au, 1'b1});
         step(k - 1);
         chk("R4 not yet expired irq", {31'b0, irq}, 32'h0);
         rd(4'hC, v); chk("R4 not yet expired status", v, 32'h0);
         step(1);
         chk("R10 irq on expiry", {31'b0, irq}, 32'h1);
         rd(4'hC, v); chk("R4 status at N*(P+1)", v, 32'h1);
         rd(4'h4, v);
         if (au) chk("R6 auto refill", v, {16'h0, n});
         else    chk("R5 one-shot holds 0", v, 32'h0);
         step(1);
         chk("R10 irq single cycle", {31'b0, irq}, 32'h0);
      end

      // R5: one-shot stays stopped
      step(20);
      rd(4'h4, v); chk("R5 stays stopped", v, 32'h0);

      // R8: enable rise with zero count preloads in auto mode only
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h1);
      wr(4'h0, 32'd6);
      wr(4'h4, 32'd0);
      wr(4'h8, 32'h0000_0001);
      step(3);
      rd(4'h4, v); chk("R8 one-shot enable no preload", v, 32'h0);
      rd(4'hC, v); chk("R8 no expiry from zero", v, 32'h0);
      wr(4'h8, 32'h0);
      wr(4'h8, 32'h0000_0003);
      rd(4'h4, v); chk("R8 preload from reload", v, 32'd6);

      // R10: auto-reload keeps expiring, no new pulse until cleared
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h1);
      wr(4'h0, 32'd2);
      wr(4'h8, 32'h0000_0003);
      pulses = 0;
      for (int c = 0; c < 8; c++) begin step(1); if (irq) pulses++; end
      chk("R10 one pulse while status held", 32'(pulses), 32'd1);
      wr(4'hC, 32'h1);
      pulses = 0;
      for (int c = 0; c < 3; c++) begin step(1); if (irq) pulses++; end
      chk("R10 pulse again after clear", 32'(pulses), 32'd1);

      // R9: clear works, set wins over clear on the expiry edge
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h1);
      rd(4'hC, v); chk("R9 clear", v, 32'h0);
      wr(4'h0, 32'd3);
      wr(4'h8, 32'h0000_0001);
      step(2);
      wr(4'hC, 32'h1);
      rd(4'hC, v); chk("R9 set wins", v, 32'h1);

      // R11: count write on the expiry edge wins
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h1);
      wr(4'h0, 32'd3);
      wr(4'h8, 32'h0000_0001);
      step(2);
      wr(4'h4, 32'd5);
      rd(4'hC, v); chk("R11 no expiry on write", v, 32'h0);
      rd(4'h4, v); chk("R11 new count", v, 32'd5);
      step(4);
      chk("R11 expires from new count", {31'b0, irq}, 32'h0);
      step(1);
      chk("R11 expires from new count", {31'b0, irq}, 32'h1);

      // R1: mid-run reset
      wr(4'h8, 32'h0000_0303);
      rst = 1'b1; step(1); rst = 1'b0;
      for (int a = 0; a < 16; a += 4) begin
         rd(4'(a), v); chk("R1 reset clears", v, 32'h0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule